// File: doc/BRIEF.md
# Interrupt Source Pending Gateway

This block keeps one pending bit for each of `N_SRC` interrupt wires of a direct-delivery interrupt controller. Each source carries a three-bit mode that picks how its raw wire is rectified: off, rising edge, falling edge, active-high level or active-low level. Each source also has an enable bit. The block presents pending AND enabled, one cycle late, to a downstream priority selector.

In the two level modes the pending bit tracks the rectified wire in both directions. When a peripheral drops its line, the pending bit falls on the next clock, so a later claim never sees a stale request. In the edge modes, a detected edge latches pending. Only a claim or a software clear removes it.

Software reaches the block only through single-cycle write strobes: mode write, enable set and clear, pending set and clear, and claim. Each source also produces a one-cycle update pulse whenever its pending bit actually changes value.

Top module: `irq_gateway`

## Requirements
- R1: After reset every pending bit, every enable bit, every `irq_o` bit and every `upd_o` bit is 0, and every source is in the off mode.
- R2: Mode codes are 3'd0 off, 3'd4 rising edge, 3'd5 falling edge, 3'd6 level high and 3'd7 level low. Every other code acts as off. An off source holds pending at 0 whatever its wire does and whatever software set strobe arrives.
- R3: In level-high mode, pending equals the wire value sampled at the previous clock edge, both when the wire rises and when it falls.
- R4: In level-low mode, pending equals the inverse of the wire value sampled at the previous clock edge.
- R5: In either level mode, software pending set and clear strobes have no effect on pending.
- R6: In rising-edge mode, a 0-to-1 wire transition sets pending at the next edge, and pending stays set after the wire falls.
- R7: In falling-edge mode, a 1-to-0 wire transition sets pending at the next edge, and pending stays set after the wire rises.
- R8: In an edge mode, a claim or a software clear drops pending and a software set raises it. When an edge or a set arrives in the same cycle as a clear or a claim, pending ends up 1.
- R9: In a level mode, a claim clears pending for one cycle. If the rectified wire is still high, pending returns at the following edge. If the rectified wire is low, pending stays 0.
- R10: `upd_o[i]` is 1 for exactly the one cycle that follows a change of pending bit i, and it is 0 at every other time.
- R11: `irq_o[i]` equals pending AND enable of source i as registered one edge earlier. When an enable set and an enable clear arrive together, the clear wins.
- R12: A mode write to a source clears that source's pending bit at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt wires |
| cfg_we_i | input | N_SRC | Mode write strobe per source |
| cfg_mode_i | input | 3 | Mode code written by `cfg_we_i` |
| en_set_i | input | N_SRC | Enable set strobe |
| en_clr_i | input | N_SRC | Enable clear strobe |
| pend_set_i | input | N_SRC | Software pending set strobe |
| pend_clr_i | input | N_SRC | Software pending clear strobe |
| claim_i | input | N_SRC | Claim strobe, clears pending |
| pending_o | output | N_SRC | Current pending bits |
| upd_o | output | N_SRC | One-cycle pulse after a pending change |
| irq_o | output | N_SRC | Registered pending AND enable |

## Verification
The bench builds the block with its default of four sources. With four sources, a level-high, a level-low, a rising-edge and a falling-edge source can each hold its own configuration at the same time. This lets the bench confirm that strobes aimed at one source leave the other sources alone. Source 3 is also moved through a reserved mode code and back to off, which reaches the decode fallback without disturbing the other lanes.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 3'd0,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_LVL_HI = 3'd6,
    SM_LVL_LO = 3'd7
  } src_mode_e;

  function automatic src_mode_e decode_mode(input logic [MODE_W-1:0] code);
    case (code)
      3'd4:    return SM_RISE;
      3'd5:    return SM_FALL;
      3'd6:    return SM_LVL_HI;
      3'd7:    return SM_LVL_LO;
      default: return SM_OFF;
    endcase
  endfunction
endpackage

// File: rtl/gw_src_cfg.sv
module gw_src_cfg
  import irq_gw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  output src_mode_e         mode_o,
  output logic              en_o
);
  src_mode_e mode_q;
  logic      en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SM_OFF;
      en_q   <= 1'b0;
    end else begin
      if (cfg_we_i) mode_q <= decode_mode(cfg_mode_i);
      // clear wins over set
      if (en_clr_i)      en_q <= 1'b0;
      else if (en_set_i) en_q <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
endmodule

// File: rtl/gw_rectify.sv
module gw_rectify
  import irq_gw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      raw_i,
  input  src_mode_e mode_i,
  output logic      rect_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_i;
  end

  always_comb begin
    case (mode_i)
      SM_RISE:   rect_o = raw_i & ~raw_q;
      SM_FALL:   rect_o = ~raw_i & raw_q;
      SM_LVL_HI: rect_o = raw_i;
      SM_LVL_LO: rect_o = ~raw_i;
      default:   rect_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gw_pending_cell.sv
module gw_pending_cell
  import irq_gw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  src_mode_e mode_i,
  input  logic      rect_i,
  input  logic      cfg_we_i,
  input  logic      claim_i,
  input  logic      sw_set_i,
  input  logic      sw_clr_i,
  output logic      pend_o,
  output logic      chg_o
);
  logic pend_q, pend_d;
  logic is_lvl, is_edge;

  assign is_lvl  = (mode_i == SM_LVL_HI) || (mode_i == SM_LVL_LO);
  assign is_edge = (mode_i == SM_RISE) || (mode_i == SM_FALL);

  always_comb begin
    pend_d = pend_q;
    if (cfg_we_i) begin
      pend_d = 1'b0;
    end else if (is_lvl) begin
      // mirrors rectified input; claim drops it for one cycle only
      pend_d = rect_i & ~claim_i;
    end else if (is_edge) begin
      if (rect_i || sw_set_i)       pend_d = 1'b1;
      else if (claim_i || sw_clr_i) pend_d = 1'b0;
    end else begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign chg_o  = pend_d ^ pend_q;

  // R3 R4 R5
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_lvl && !cfg_we_i && !claim_i) |=> (pend_q == $past(rect_i)));

  // R2
  off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_lvl && !is_edge) |-> !pend_q);

  // R8
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && !cfg_we_i && !rect_i && !sw_set_i && !claim_i && !sw_clr_i)
    |=> $stable(pend_q));

  // R9
  claim_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && !(is_edge && (rect_i || sw_set_i))) |=> !pend_q);

  // R12
  cfg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !pend_q);
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
  import irq_gw_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [N_SRC-1:0]  en_set_i,
  input  logic [N_SRC-1:0]  en_clr_i,
  input  logic [N_SRC-1:0]  pend_set_i,
  input  logic [N_SRC-1:0]  pend_clr_i,
  input  logic [N_SRC-1:0]  claim_i,
  output logic [N_SRC-1:0]  pending_o,
  output logic [N_SRC-1:0]  upd_o,
  output logic [N_SRC-1:0]  irq_o
);
  logic [N_SRC-1:0] pend_vec, en_vec, chg_vec, rect_vec;
  logic [N_SRC-1:0] irq_q, upd_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    src_mode_e mode;

    gw_src_cfg u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i[i]),
      .cfg_mode_i (cfg_mode_i),
      .en_set_i   (en_set_i[i]),
      .en_clr_i   (en_clr_i[i]),
      .mode_o     (mode),
      .en_o       (en_vec[i])
    );

    gw_rectify u_rect (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (src_i[i]),
      .mode_i (mode),
      .rect_o (rect_vec[i])
    );

    gw_pending_cell u_pend (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .rect_i   (rect_vec[i]),
      .cfg_we_i (cfg_we_i[i]),
      .claim_i  (claim_i[i]),
      .sw_set_i (pend_set_i[i]),
      .sw_clr_i (pend_clr_i[i]),
      .pend_o   (pend_vec[i]),
      .chg_o    (chg_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      upd_q <= '0;
    end else begin
      irq_q <= pend_vec & en_vec;
      upd_q <= chg_vec;
    end
  end

  assign pending_o = pend_vec;
  assign irq_o     = irq_q;
  assign upd_o     = upd_q;

  // R11
  irq_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_q == $past(pend_vec & en_vec)));

  // R10
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (upd_q == (pend_vec ^ $past(pend_vec))));
endmodule

// File: tb/irq_gateway_test.sv
`timescale 1ns/1ps
module irq_gateway_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] src = '0, cfg_we = '0, en_set = '0, en_clr = '0;
  logic [N-1:0] pset = '0, pclr = '0, claim = '0;
  logic [2:0]   cfg_mode = 3'd0;
  logic [N-1:0] pending, upd, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_gateway #(.N_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .cfg_we_i(cfg_we),
    .cfg_mode_i(cfg_mode), .en_set_i(en_set), .en_clr_i(en_clr),
    .pend_set_i(pset), .pend_clr_i(pclr), .claim_i(claim),
    .pending_o(pending), .upd_o(upd), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_mode(input int i, input logic [2:0] code);
    cfg_mode = code; cfg_we[i] = 1'b1; tick(); cfg_we[i] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pending", pending, 0);
    chk("R1 irq", irq, 0);
    chk("R1 upd", upd, 0);
    src = '1; tick(); tick();
    chk("R2 off ignores wire", pending, 0);
    pset = '1; tick(); pset = '0;
    chk("R2 off ignores set", pending, 0);
    src = '0; tick();
  endtask

  task automatic t_level_high();
    set_mode(0, 3'd6);
    src[0] = 1'b1; tick();
    chk("R3 rise", pending[0], 1);
    chk("R10 pulse on set", upd[0], 1);
    tick();
    chk("R10 no pulse when steady", upd[0], 0);
    chk("R3 hold", pending[0], 1);
    src[0] = 1'b0; tick();
    chk("R3 fall clears", pending[0], 0);
    chk("R10 pulse on clear", upd[0], 1);
  endtask

  task automatic t_level_low();
    src[1] = 1'b1;
    set_mode(1, 3'd7);
    chk("R4 high wire", pending[1], 0);
    src[1] = 1'b0; tick();
    chk("R4 low wire sets", pending[1], 1);
    src[1] = 1'b1; tick();
    chk("R4 high wire clears", pending[1], 0);
  endtask

  task automatic t_level_sw();
    pset[1] = 1'b1; tick(); pset[1] = 1'b0;
    chk("R5 set ignored", pending[1], 0);
    src[1] = 1'b0; tick();
    pclr[1] = 1'b1; tick(); pclr[1] = 1'b0;
    chk("R5 clear ignored", pending[1], 1);
    src[1] = 1'b1; tick();
    chk("R5 other lane untouched", pending[0], 0);
  endtask

  task automatic t_level_claim();
    src[0] = 1'b1; tick();
    claim[0] = 1'b1; tick(); claim[0] = 1'b0;
    chk("R9 claim clears", pending[0], 0);
    tick();
    chk("R9 wire still high re-pends", pending[0], 1);
    src[0] = 1'b0; tick();
    claim[0] = 1'b1; tick(); claim[0] = 1'b0; tick();
    chk("R9 stays clear after wire low", pending[0], 0);
  endtask

  task automatic t_rising();
    src[2] = 1'b0;
    set_mode(2, 3'd4);
    src[2] = 1'b1; tick();
    chk("R6 edge sets", pending[2], 1);
    src[2] = 1'b0; tick(); tick();
    chk("R6 sticky after fall", pending[2], 1);
    claim[2] = 1'b1; tick(); claim[2] = 1'b0;
    chk("R8 claim clears", pending[2], 0);
    pset[2] = 1'b1; tick(); pset[2] = 1'b0;
    chk("R8 sw set", pending[2], 1);
    pclr[2] = 1'b1; tick(); pclr[2] = 1'b0;
    chk("R8 sw clear", pending[2], 0);
    src[2] = 1'b1; claim[2] = 1'b1; tick(); claim[2] = 1'b0;
    chk("R8 edge beats claim", pending[2], 1);
    set_mode(2, 3'd4);
    chk("R12 mode write clears", pending[2], 0);
    tick();
    chk("R6 level high no new edge", pending[2], 0);
  endtask

  task automatic t_falling();
    src[3] = 1'b1;
    set_mode(3, 3'd5);
    tick();
    chk("R7 no edge yet", pending[3], 0);
    src[3] = 1'b0; tick();
    chk("R7 fall sets", pending[3], 1);
    src[3] = 1'b1; tick();
    chk("R7 sticky after rise", pending[3], 1);
  endtask

  task automatic t_reserved();
    set_mode(3, 3'd2);
    chk("R12 clear on reserved write", pending[3], 0);
    src[3] = 1'b0; tick(); src[3] = 1'b1; tick();
    chk("R2 reserved code acts off", pending[3], 0);
    pset[3] = 1'b1; tick(); pset[3] = 1'b0;
    chk("R2 reserved ignores set", pending[3], 0);
    set_mode(3, 3'd0);
    src[3] = 1'b0; tick();
    chk("R2 off mode", pending[3], 0);
  endtask

  task automatic t_enable();
    src[0] = 1'b1; tick();
    chk("R11 disabled", irq[0], 0);
    en_set[0] = 1'b1; tick(); en_set[0] = 1'b0;
    chk("R11 one cycle latency", irq[0], 0);
    tick();
    chk("R11 irq asserted", irq[0], 1);
    en_set[0] = 1'b1; en_clr[0] = 1'b1; tick(); en_set[0] = 1'b0; en_clr[0] = 1'b0;
    chk("R11 still registered", irq[0], 1);
    tick();
    chk("R11 clear wins", irq[0], 0);
    en_set[0] = 1'b1; tick(); en_set[0] = 1'b0; tick();
    src[0] = 1'b0; tick();
    chk("R11 irq lags pending", irq[0], 1);
    tick();
    chk("R11 irq drops", irq[0], 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_level_high();
    t_level_low();
    t_level_sw();
    t_level_claim();
    t_rising();
    t_falling();
    t_reserved();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule